// File: doc/BRIEF.md
# Core Sleep and Lockup Controller

This block tracks whether a processor core is running, in light sleep, in deep sleep or locked up after a fault it could not handle, and it drives the clock and memory enables that follow from that state. The instruction decoder provides single-cycle strobes for the wait-for-interrupt and wait-for-event instructions, together with a bit that selects how deep the sleep should be. The exception logic reports hard faults, which handler is currently running, NMIs and pending interrupts. Event and debug-wake lines arrive from the rest of the system.

Wait-for-interrupt always puts the core to sleep. Wait-for-event first checks a one-bit latch that records events seen while the core was running. If that latch is set, the instruction only clears it and execution carries on without sleeping. A hard fault that is raised while the NMI or hard-fault handler is running stops the core in a locked state. The rule for leaving that state depends on which of the two handlers was running when the fault occurred.

All outputs are decoded from the registered state. A wake condition seen in one cycle therefore restores every enable at the next clock edge.

Top module: `core_sleep_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the state returns to run (code 0), the event latch is cleared, and after that edge all three enables are 1 and `halted_o` is 0.
- R2: In run, a `wfi_i` strobe with `deep_sel_i`=0 gives state code 1 (light sleep) at the next edge: `core_clk_en_o`=0, `hf_clk_en_o`=1, `flash_en_o`=1 and `halted_o`=1.
- R3: A sleep entry with `deep_sel_i`=1 gives state code 2 (deep sleep), where all three enables are 0 and `halted_o`=1.
- R4: A `wfe_i` strobe while the event latch is set, or while `event_i` is high in the same cycle, keeps the state at run and clears the latch, so the next `wfe_i` sleeps.
- R5: A `wfe_i` strobe with the latch clear and `event_i` low enters sleep at the depth chosen by `deep_sel_i`.
- R6: `event_i` seen in run sets the event latch. Events seen in any other state leave it unchanged.
- R7: From sleep entered by `wfi_i`, `irq_pend_i` returns the state to run at the next edge, and `event_i` alone has no effect.
- R8: From sleep entered by `wfe_i`, either `event_i` or `irq_pend_i` returns the state to run at the next edge.
- R9: `dbg_wake_i` returns either sleep state to run at the next edge.
- R10: In run, `hard_fault_i` while `nmi_act_i` or `hf_act_i` is high gives state code 3 (lockup) at the next edge. This takes priority over `wfi_i` and `wfe_i`. In lockup `halted_o`=1 and all enables are 1. A hard fault with neither handler flag high leaves the state unchanged.
- R11: A lockup entered with `nmi_act_i`=0 is left for run at the next edge after `nmi_i`.
- R12: A lockup entered with `nmi_act_i`=1 ignores `nmi_i` and is left only by reset.
- R13: In lockup, `wfi_i`, `wfe_i`, `irq_pend_i`, `event_i` and `dbg_wake_i` have no effect on the state.
- R14: On a wake from deep sleep, all three enables return to 1 and `halted_o` returns to 0 at the same edge that the state returns to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wfi_i | input | 1 | Decoded wait-for-interrupt strobe |
| wfe_i | input | 1 | Decoded wait-for-event strobe |
| deep_sel_i | input | 1 | Sleep depth select: 1 selects deep sleep |
| hard_fault_i | input | 1 | Hard fault raised this cycle |
| nmi_i | input | 1 | NMI request |
| nmi_act_i | input | 1 | NMI handler currently running |
| hf_act_i | input | 1 | Hard-fault handler currently running |
| irq_pend_i | input | 1 | At least one interrupt is pending |
| event_i | input | 1 | External or software event |
| dbg_wake_i | input | 1 | Debug wake request |
| core_clk_en_o | output | 1 | Core clock enable |
| hf_clk_en_o | output | 1 | High-frequency oscillator and peripheral clock enable |
| flash_en_o | output | 1 | Flash enable |
| halted_o | output | 1 | No instructions are executing |
| state_o | output | 2 | State code: 0 run, 1 light sleep, 2 deep sleep, 3 lockup |

## Verification
The case that is hardest to reach is the distinction inside lockup. From the ports, the two kinds of lockup look the same: state code 3 with the same enables. They differ only in how they respond to a later NMI. The stimulus therefore enters lockup twice, once with only the hard-fault handler flag set and once with the NMI handler flag set, and sends the same NMI after each, expecting a release in the first case and no release in the second. The event latch is equally hidden. It is observed through its only effect, which is whether a following wait-for-event sleeps or falls through.

// File: rtl/slc_pkg.sv
package slc_pkg;

    localparam int unsigned ST_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_RUN  = 2'd0,
        ST_NAP  = 2'd1,
        ST_DEEP = 2'd2,
        ST_LOCK = 2'd3
    } slc_state_e;

    // Which instruction put the core to sleep; selects the wake sources.
    typedef enum logic {
        KIND_IRQ = 1'b0,
        KIND_EVT = 1'b1
    } slc_kind_e;

    typedef struct packed {
        logic core;
        logic hfclk;
        logic flash;
        logic halted;
    } slc_out_t;

    function automatic slc_out_t slc_decode(input slc_state_e s);
        slc_out_t o;
        unique case (s)
            ST_RUN:  o = '{core: 1'b1, hfclk: 1'b1, flash: 1'b1, halted: 1'b0};
            ST_NAP:  o = '{core: 1'b0, hfclk: 1'b1, flash: 1'b1, halted: 1'b1};
            ST_DEEP: o = '{core: 1'b0, hfclk: 1'b0, flash: 1'b0, halted: 1'b1};
            default: o = '{core: 1'b1, hfclk: 1'b1, flash: 1'b1, halted: 1'b1};
        endcase
        return o;
    endfunction

    function automatic logic slc_is_asleep(input slc_state_e s);
        return (s == ST_NAP) || (s == ST_DEEP);
    endfunction

endpackage

// File: rtl/slc_event_latch.sv
module slc_event_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic consume_i,
    input  logic event_i,
    output logic flag_o,
    output logic seen_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (consume_i) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;
    // An event in the same cycle as the check counts as already latched.
    assign seen_o = flag_q | event_i;
endmodule

// File: rtl/slc_wake_detect.sv
module slc_wake_detect
    import slc_pkg::*;
(
    input  slc_state_e state_i,
    input  slc_kind_e  kind_i,
    input  logic       irq_pend_i,
    input  logic       event_i,
    input  logic       dbg_wake_i,
    output logic       wake_o
);
    logic evt_ok;

    always_comb begin
        evt_ok = (kind_i == KIND_EVT) && event_i;
        wake_o = slc_is_asleep(state_i) && (irq_pend_i || dbg_wake_i || evt_ok);
    end
endmodule

// File: rtl/slc_state_fsm.sv
module slc_state_fsm
    import slc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wfi_i,
    input  logic       wfe_i,
    input  logic       deep_sel_i,
    input  logic       hard_fault_i,
    input  logic       nmi_i,
    input  logic       nmi_act_i,
    input  logic       hf_act_i,
    input  logic       wake_i,
    input  logic       ev_seen_i,
    output logic       consume_o,
    output slc_state_e state_o,
    output slc_kind_e  kind_o
);
    slc_state_e state_q, state_n;
    slc_kind_e  kind_q, kind_n;
    logic       lock_nmi_q, lock_nmi_n;
    logic       fault_locks;
    slc_state_e sleep_tgt;

    always_comb begin
        fault_locks = hard_fault_i && (nmi_act_i || hf_act_i);
        sleep_tgt   = deep_sel_i ? ST_DEEP : ST_NAP;
        state_n     = state_q;
        kind_n      = kind_q;
        lock_nmi_n  = lock_nmi_q;
        consume_o   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (fault_locks) begin
                    state_n    = ST_LOCK;
                    lock_nmi_n = nmi_act_i;
                end else if (wfi_i) begin
                    state_n = sleep_tgt;
                    kind_n  = KIND_IRQ;
                end else if (wfe_i) begin
                    if (ev_seen_i) begin
                        consume_o = 1'b1;
                    end else begin
                        state_n = sleep_tgt;
                        kind_n  = KIND_EVT;
                    end
                end
            end
            ST_NAP, ST_DEEP: begin
                if (wake_i) state_n = ST_RUN;
            end
            default: begin
                if (nmi_i && !lock_nmi_q) state_n = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RUN;
            kind_q     <= KIND_IRQ;
            lock_nmi_q <= 1'b0;
        end else begin
            state_q    <= state_n;
            kind_q     <= kind_n;
            lock_nmi_q <= lock_nmi_n;
        end
    end

    assign state_o = state_q;
    assign kind_o  = kind_q;
endmodule

// File: rtl/core_sleep_ctrl.sv
module core_sleep_ctrl
    import slc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wfi_i,
    input  logic            wfe_i,
    input  logic            deep_sel_i,
    input  logic            hard_fault_i,
    input  logic            nmi_i,
    input  logic            nmi_act_i,
    input  logic            hf_act_i,
    input  logic            irq_pend_i,
    input  logic            event_i,
    input  logic            dbg_wake_i,
    output logic            core_clk_en_o,
    output logic            hf_clk_en_o,
    output logic            flash_en_o,
    output logic            halted_o,
    output logic [ST_W-1:0] state_o
);
    slc_state_e cur_state;
    slc_kind_e  cur_kind;
    logic       wake, consume, ev_seen, ev_flag, ev_set;
    slc_out_t   outs;

    assign ev_set = (cur_state == ST_RUN) && event_i;

    slc_event_latch u_evt (
        .clk       (clk),
        .rst       (rst),
        .set_i     (ev_set),
        .consume_i (consume),
        .event_i   (event_i),
        .flag_o    (ev_flag),
        .seen_o    (ev_seen)
    );

    slc_wake_detect u_wake (
        .state_i    (cur_state),
        .kind_i     (cur_kind),
        .irq_pend_i (irq_pend_i),
        .event_i    (event_i),
        .dbg_wake_i (dbg_wake_i),
        .wake_o     (wake)
    );

    slc_state_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .wfi_i        (wfi_i),
        .wfe_i        (wfe_i),
        .deep_sel_i   (deep_sel_i),
        .hard_fault_i (hard_fault_i),
        .nmi_i        (nmi_i),
        .nmi_act_i    (nmi_act_i),
        .hf_act_i     (hf_act_i),
        .wake_i       (wake),
        .ev_seen_i    (ev_seen),
        .consume_o    (consume),
        .state_o      (cur_state),
        .kind_o       (cur_kind)
    );

    always_comb begin
        outs          = slc_decode(cur_state);
        core_clk_en_o = outs.core;
        hf_clk_en_o   = outs.hfclk;
        flash_en_o    = outs.flash;
        halted_o      = outs.halted;
        state_o       = cur_state;
    end

    logic unused_flag;
    assign unused_flag = ev_flag;
endmodule

// File: rtl/slc_checker.sv
module slc_checker (
    input logic       clk,
    input logic       rst,
    input logic       wfi_i,
    input logic       deep_sel_i,
    input logic       hard_fault_i,
    input logic       nmi_i,
    input logic       nmi_act_i,
    input logic       hf_act_i,
    input logic       irq_pend_i,
    input logic       dbg_wake_i,
    input logic       core_clk_en_o,
    input logic       hf_clk_en_o,
    input logic       flash_en_o,
    input logic       halted_o,
    input logic [1:0] state_o
);
    assert_wfi_depth_R2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && wfi_i && !hard_fault_i)
        |=> (state_o == ($past(deep_sel_i) ? 2'd2 : 2'd1)));

    assert_deep_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2) |-> (!core_clk_en_o && !hf_clk_en_o && !flash_en_o && halted_o));

    assert_irq_wakes_R7: assert property (@(posedge clk) disable iff (rst)
        ((state_o == 2'd1 || state_o == 2'd2) && (irq_pend_i || dbg_wake_i))
        |=> (state_o == 2'd0));

    assert_fault_locks_R10: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && hard_fault_i && (nmi_act_i || hf_act_i))
        |=> (state_o == 2'd3 && halted_o));

    assert_lock_holds_R13: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3 && !nmi_i) |=> (state_o == 2'd3));

    assert_lock_exit_R12: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3) |=> (state_o == 2'd3 || state_o == 2'd0));

    assert_restore_R14: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2 && irq_pend_i)
        |=> (state_o == 2'd0 && core_clk_en_o && hf_clk_en_o && flash_en_o && !halted_o));
endmodule

bind core_sleep_ctrl slc_checker i_slc_checker (
    .clk           (clk),
    .rst           (rst),
    .wfi_i         (wfi_i),
    .deep_sel_i    (deep_sel_i),
    .hard_fault_i  (hard_fault_i),
    .nmi_i         (nmi_i),
    .nmi_act_i     (nmi_act_i),
    .hf_act_i      (hf_act_i),
    .irq_pend_i    (irq_pend_i),
    .dbg_wake_i    (dbg_wake_i),
    .core_clk_en_o (core_clk_en_o),
    .hf_clk_en_o   (hf_clk_en_o),
    .flash_en_o    (flash_en_o),
    .halted_o      (halted_o),
    .state_o       (state_o)
);

// File: tb/test_core_sleep_ctrl.sv
`timescale 1ns/1ps
module test_core_sleep_ctrl;

    typedef struct packed {
        logic       rst, wfi, wfe, deep, hf, nmi, nact, hact, irq, ev, dbg;
        logic [1:0] st;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 30;
    // fields: rst wfi wfe deep hf nmi nact hact irq ev dbg | expected state | requirement
    localparam vec_t TBL [NV] = '{
        '{1,0,0,0,0,0,0,0,0,0,0, 2'd0, 4'd1 },  // R1 reset
        '{0,0,0,0,0,0,0,0,0,0,0, 2'd0, 4'd1 },
        '{0,1,0,0,0,0,0,0,0,0,0, 2'd1, 4'd2 },  // R2 light sleep
        '{0,0,0,0,0,0,0,0,0,1,0, 2'd1, 4'd7 },  // R7 event ignored
        '{0,0,0,0,0,0,0,0,1,0,0, 2'd0, 4'd7 },  // R7 irq wake
        '{0,1,0,1,0,0,0,0,0,0,0, 2'd2, 4'd3 },  // R3 deep sleep
        '{0,0,0,0,0,0,0,0,0,0,0, 2'd2, 4'd3 },
        '{0,0,0,0,0,0,0,0,1,0,0, 2'd0, 4'd14},  // R14 restore
        '{0,0,1,0,0,0,0,0,0,0,0, 2'd1, 4'd5 },  // R5 wfe sleeps
        '{0,0,0,0,0,0,0,0,0,1,0, 2'd0, 4'd8 },  // R8 event wake
        '{0,0,0,0,0,0,0,0,0,1,0, 2'd0, 4'd6 },  // R6 latch set
        '{0,0,1,0,0,0,0,0,0,0,0, 2'd0, 4'd4 },  // R4 fall through
        '{0,0,1,1,0,0,0,0,0,0,0, 2'd2, 4'd4 },  // R4 latch consumed
        '{0,0,0,0,0,0,0,0,1,0,0, 2'd0, 4'd8 },  // R8 irq wake
        '{0,1,0,0,0,0,0,0,0,0,0, 2'd1, 4'd2 },
        '{0,0,0,0,0,0,0,0,0,0,1, 2'd0, 4'd9 },  // R9 debug wake
        '{0,0,1,1,0,0,0,0,0,0,0, 2'd2, 4'd5 },
        '{0,0,0,0,0,0,0,0,0,0,1, 2'd0, 4'd9 },
        '{0,0,0,0,1,0,0,0,0,0,0, 2'd0, 4'd10},  // R10 fault outside handler
        '{0,0,0,0,1,0,0,1,0,0,0, 2'd3, 4'd10},  // R10 lockup
        '{0,1,1,0,0,0,0,0,1,1,1, 2'd3, 4'd13},  // R13 ignored
        '{0,0,0,0,0,1,0,0,0,0,0, 2'd0, 4'd11},  // R11 nmi release
        '{0,0,0,0,1,0,1,0,0,0,0, 2'd3, 4'd10},
        '{0,0,0,0,0,1,0,0,0,0,0, 2'd3, 4'd12},  // R12 nmi ignored
        '{0,0,0,0,0,1,0,0,0,0,0, 2'd3, 4'd12},
        '{1,0,0,0,0,0,0,0,0,0,0, 2'd0, 4'd12},  // R12 reset releases
        '{0,0,0,0,0,0,0,0,0,1,0, 2'd0, 4'd6 },
        '{1,0,0,0,0,0,0,0,0,0,0, 2'd0, 4'd1 },
        '{0,0,1,0,0,0,0,0,0,0,0, 2'd1, 4'd1 },  // R1 latch cleared by reset
        '{0,0,0,0,0,0,0,0,1,0,0, 2'd0, 4'd7 }
    };

    logic clk = 1'b0;
    logic rst, wfi, wfe, deep, hf, nmi, nact, hact, irq, ev, dbg;
    logic core_en, hf_en, fl_en, halted;
    logic [1:0] st;
    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    core_sleep_ctrl i_core_sleep_ctrl (
        .clk(clk), .rst(rst), .wfi_i(wfi), .wfe_i(wfe), .deep_sel_i(deep),
        .hard_fault_i(hf), .nmi_i(nmi), .nmi_act_i(nact), .hf_act_i(hact),
        .irq_pend_i(irq), .event_i(ev), .dbg_wake_i(dbg),
        .core_clk_en_o(core_en), .hf_clk_en_o(hf_en), .flash_en_o(fl_en),
        .halted_o(halted), .state_o(st)
    );

    // {core, hf, flash, halted} expected for each state code
    function automatic logic [3:0] exp_out(input logic [1:0] s);
        case (s)
            2'd0:    return 4'b1110;
            2'd1:    return 4'b0111;
            2'd2:    return 4'b0001;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic step(input vec_t v);
        logic [5:0] got, want;
        @(negedge clk);
        {rst, wfi, wfe, deep, hf, nmi, nact, hact, irq, ev, dbg} =
            {v.rst, v.wfi, v.wfe, v.deep, v.hf, v.nmi, v.nact, v.hact, v.irq, v.ev, v.dbg};
        @(posedge clk);
        #1;
        got  = {st, core_en, hf_en, fl_en, halted};
        want = {v.st, exp_out(v.st)};
        n_cmp++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL R%0d: got state/en/halt=%b expected %b", v.req, got, want);
        end
    endtask

    initial begin
        {rst, wfi, wfe, deep, hf, nmi, nact, hact, irq, ev, dbg} = '0;
        rst = 1'b1;
        for (int i = 0; i < NV; i++) step(TBL[i]);
        // R4: event in the same cycle as the wfe strobe falls through
        step('{0,0,1,0,0,0,0,0,0,1,0, 2'd0, 4'd4});
        step('{0,0,1,0,0,0,0,0,0,0,0, 2'd1, 4'd4});
        step('{0,0,0,0,0,0,0,0,1,0,0, 2'd0, 4'd7});
        // R10: fault in handler beats a simultaneous wfi
        step('{0,1,0,1,1,0,0,1,0,0,0, 2'd3, 4'd10});
        step('{0,0,0,0,0,1,0,0,0,0,0, 2'd0, 4'd11});
        // R1: reset during deep sleep
        step('{0,1,0,1,0,0,0,0,0,0,0, 2'd2, 4'd3});
        step('{1,0,0,0,0,0,0,0,0,0,0, 2'd0, 4'd1});
        // R9: debug wake from wfe light sleep
        step('{0,0,1,0,0,0,0,0,0,0,0, 2'd1, 4'd5});
        step('{0,0,0,0,0,0,0,0,0,0,1, 2'd0, 4'd9});
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule